// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block is the device-side command logic of a serial flash that accepts a page-program command over an SPI mode-0 link. It samples chip select, serial clock and serial data with the system clock, collects the opcode, a three-byte start address and the data bytes, and stages the data in a one-page buffer. Data written past the end of the page wraps back to the start of that page.

Nothing reaches the memory array until chip select is released. At that point the engine checks that whole bytes were sent, that the address and at least one data byte arrived, and that the target sector is not locked. A command that passes these checks starts a timed program cycle. The cycle merges the staged bytes into a behavioural array and can only clear bits. A separate opcode arms the write-enable latch, and a status opcode streams out the busy, write-enable and program-error flags.

A peek port reads the behavioural array directly so that its contents can be observed. Address bits above the array size are ignored, so those addresses alias onto the array.

Top module: `pp_flash_prog`

## Requirements
- R1: Opcode 02h is followed by three address bytes, most significant first. Data bytes land at page offset address[7:0] and upward. The offset wraps from FFh to 00h in the same page, so a start at 0000FEh with bytes 11h, 22h, 33h writes offsets FEh, FFh and 00h.
- R2: Opcode 06h sets the write-enable latch at the end of that byte. A program command sent while the latch is clear is ignored and leaves the array unchanged.
- R3: When more than 256 data bytes are sent, each page offset holds the last byte sent for it.
- R4: Page locations that received no data during the command keep their previous contents.
- R5: A program command aborts with nothing programmed and the write-enable latch cleared in any of these cases: chip select rises after a bit count that is not a multiple of eight, or before three address bytes and one data byte are complete.
- R6: With sect_lock[i] set, a program command whose start address lies in sector i is ignored. Sector i is address bits [9:9] with the default sizes. The latch is cleared.
- R7: A valid command raises busy for exactly PROG_CYCLES system clocks, counted from the release of chip select. The write-enable latch is cleared when the cycle starts.
- R8: Opcode 05h returns the status byte most significant bit first, starting with the byte after the opcode. The byte has busy in bit 0, write-enable in bit 1 and program error in bit 5, with all other bits 0. The byte repeats while chip select stays low.
- R9: While busy, only opcode 05h is honoured. A 06h sent during the cycle leaves the latch clear.
- R10: Programming ANDs each staged byte into the array. The error bit is set if any programmed location differs from its intended data, and it is cleared when the next program cycle starts.
- R11: After reset the latch, busy and error flags are 0 and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out, carries the status byte |
| sect_lock | input | NUM_SECT | One lock bit per sector |
| peek_addr | input | MEM_AW | Array byte index for observation |
| peek_data | output | 8 | Array byte at peek_addr |

## Verification
The assertions take for granted that the serial clock is at least four system clocks per phase. They also take for granted that data and chip select change only while the serial clock is low, so the synchronised edges arrive in order. The stimulus drives every serial line on the falling system-clock edge and holds each phase for four clocks. It waits eight clocks after each chip-select release. It changes the lock vector only between frames. Random programs pick start addresses inside the unlocked sector and lengths of 1 to 40 bytes. Directed frames cover the cases around them: wrap, overlong data, truncation, a locked target and a bit clash.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_RDST = 8'h05;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam int STB_BUSY = 0;
  localparam int STB_WEL  = 1;
  localparam int STB_ERR  = 5;
  typedef enum logic [2:0] {CS_OPC, CS_ADDR, CS_DATA, CS_STAT, CS_IGN} cmd_st_e;
endpackage

// File: rtl/pp_spi_shift.sv
module pp_spi_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       frame_act_o,
  output logic       frame_end_o,
  output logic       aligned_o,
  output logic       byte_vld_o,
  output logic [7:0] rx_byte_o,
  output logic       miso_o
);
  logic [1:0] cs_s_q, sck_s_q, mosi_s_q;
  logic       cs_d_q, sck_d_q;
  logic [2:0] bit_cnt_q, bit_cnt_n;
  logic [6:0] sh_q, sh_n;
  logic [7:0] tx_q, tx_n;
  logic       act, sck_rise, sck_fall;

  assign act      = ~cs_s_q[1];
  assign sck_rise = sck_s_q[1] & ~sck_d_q;
  assign sck_fall = ~sck_s_q[1] & sck_d_q;

  assign frame_act_o = act;
  assign frame_end_o = cs_s_q[1] & ~cs_d_q;
  assign aligned_o   = (bit_cnt_q == 3'd0);
  assign byte_vld_o  = act & sck_rise & (bit_cnt_q == 3'd7);
  assign rx_byte_o   = {sh_q, mosi_s_q[1]};
  assign miso_o      = tx_q[7];

  always_comb begin
    bit_cnt_n = bit_cnt_q;
    sh_n      = sh_q;
    tx_n      = tx_q;
    if (!act) begin
      bit_cnt_n = 3'd0;
    end else if (sck_rise) begin
      bit_cnt_n = bit_cnt_q + 3'd1;
      sh_n      = {sh_q[5:0], mosi_s_q[1]};
    end
    // reload at each byte boundary, shift on falling edges inside a byte
    if (byte_vld_o) begin
      tx_n = tx_byte_i;
    end else if (act && sck_fall && (bit_cnt_q != 3'd0)) begin
      tx_n = {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s_q    <= 2'b11;
      sck_s_q   <= 2'b00;
      mosi_s_q  <= 2'b00;
      cs_d_q    <= 1'b1;
      sck_d_q   <= 1'b0;
      bit_cnt_q <= 3'd0;
      sh_q      <= 7'd0;
      tx_q      <= 8'd0;
    end else begin
      cs_s_q    <= {cs_s_q[0], cs_n_i};
      sck_s_q   <= {sck_s_q[0], sck_i};
      mosi_s_q  <= {mosi_s_q[0], mosi_i};
      cs_d_q    <= cs_s_q[1];
      sck_d_q   <= sck_s_q[1];
      bit_cnt_q <= bit_cnt_n;
      sh_q      <= sh_n;
      tx_q      <= tx_n;
    end
  end
endmodule

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [7:0]       wr_data_i,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_used_o
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] used_q, used_n;

  always_comb begin
    used_n = used_q;
    if (clr_i) begin
      used_n = '0;
    end else if (wr_i) begin
      used_n[wr_off_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_n;
  end

  always_ff @(posedge clk) begin
    if (wr_i) data_q[wr_off_i] <= wr_data_i;
  end

  assign rd_data_o = data_q[rd_off_i];
  assign rd_used_o = used_q[rd_off_i];
endmodule

// File: rtl/pp_prog_seq.sv
module pp_prog_seq #(
  parameter int MEM_BYTES   = 1024,
  parameter int PAGE_BYTES  = 256,
  parameter int PROG_CYCLES = 1000,
  localparam int MEM_AW = $clog2(MEM_BYTES),
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = MEM_AW - OFF_W,
  localparam int CYC_W  = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PG_W-1:0]   page_i,
  output logic [OFF_W-1:0]  buf_off_o,
  input  logic [7:0]        buf_data_i,
  input  logic              buf_used_i,
  output logic              busy_o,
  output logic              err_o,
  input  logic [MEM_AW-1:0] peek_addr_i,
  output logic [7:0]        peek_data_o
);
  logic             busy_q, busy_n, err_q, err_n;
  logic [CYC_W-1:0] cyc_q, cyc_n;
  logic [PG_W-1:0]  page_q, page_n;
  logic [7:0]       mem_q [MEM_BYTES];
  logic             step;
  logic [MEM_AW-1:0] widx;
  logic [7:0]       merged;

  assign buf_off_o = cyc_q[OFF_W-1:0];
  assign step      = busy_q && (cyc_q < CYC_W'(PAGE_BYTES)) && buf_used_i;
  assign widx      = {page_q, cyc_q[OFF_W-1:0]};
  assign merged    = mem_q[widx] & buf_data_i;

  always_comb begin
    busy_n = busy_q;
    err_n  = err_q;
    cyc_n  = cyc_q;
    page_n = page_q;
    if (start_i) begin
      busy_n = 1'b1;
      err_n  = 1'b0;
      cyc_n  = '0;
      page_n = page_i;
    end else if (busy_q) begin
      cyc_n = cyc_q + CYC_W'(1);
      if (cyc_q == CYC_W'(PROG_CYCLES - 1)) busy_n = 1'b0;
      if (step && (merged != buf_data_i)) err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cyc_q  <= '0;
      page_q <= '0;
    end else begin
      busy_q <= busy_n;
      err_q  <= err_n;
      cyc_q  <= cyc_n;
      page_q <= page_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (step) begin
      mem_q[widx] <= merged;
    end
  end

  assign busy_o      = busy_q;
  assign err_o       = err_q;
  assign peek_data_o = mem_q[peek_addr_i];
endmodule

// File: rtl/pp_flash_prog.sv
module pp_flash_prog
  import pp_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int PAGE_BYTES  = 256,
  parameter int SECT_BYTES  = 512,
  parameter int PROG_CYCLES = 1000,
  localparam int MEM_AW   = $clog2(MEM_BYTES),
  localparam int OFF_W    = $clog2(PAGE_BYTES),
  localparam int SECT_W   = $clog2(SECT_BYTES),
  localparam int NUM_SECT = MEM_BYTES / SECT_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_cs_n,
  input  logic                spi_sck,
  input  logic                spi_mosi,
  output logic                spi_miso,
  input  logic [NUM_SECT-1:0] sect_lock,
  input  logic [MEM_AW-1:0]   peek_addr,
  output logic [7:0]          peek_data
);
  cmd_st_e           st_q, st_n;
  logic [MEM_AW-1:0] addr_q, addr_n;
  logic [1:0]        acnt_q, acnt_n;
  logic [OFF_W-1:0]  off_q, off_n;
  logic              got_q, got_n, wel_q, wel_n;
  logic              frame_act, frame_end, aligned, byte_vld, miso_bit;
  logic [7:0]        rx_byte, stat_byte, buf_data;
  logic              buf_clr, buf_wr, buf_used, prog_go, busy, err, tgt_locked;
  logic [OFF_W-1:0]  buf_rd_off;

  pp_spi_shift u_spi (
    .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
    .tx_byte_i(stat_byte), .frame_act_o(frame_act), .frame_end_o(frame_end),
    .aligned_o(aligned), .byte_vld_o(byte_vld), .rx_byte_o(rx_byte), .miso_o(miso_bit)
  );

  pp_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .wr_i(buf_wr), .wr_off_i(off_q),
    .wr_data_i(rx_byte), .rd_off_i(buf_rd_off), .rd_data_o(buf_data), .rd_used_o(buf_used)
  );

  pp_prog_seq #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(prog_go), .page_i(addr_q[MEM_AW-1:OFF_W]),
    .buf_off_o(buf_rd_off), .buf_data_i(buf_data), .buf_used_i(buf_used),
    .busy_o(busy), .err_o(err), .peek_addr_i(peek_addr), .peek_data_o(peek_data)
  );

  assign tgt_locked = sect_lock[addr_q[MEM_AW-1:SECT_W]];
  assign spi_miso   = (st_q == CS_STAT) & miso_bit;

  always_comb begin
    stat_byte           = 8'd0;
    stat_byte[STB_BUSY] = busy;
    stat_byte[STB_WEL]  = wel_q;
    stat_byte[STB_ERR]  = err;
  end

  always_comb begin
    st_n    = st_q;
    addr_n  = addr_q;
    acnt_n  = acnt_q;
    off_n   = off_q;
    got_n   = got_q;
    wel_n   = wel_q;
    buf_clr = 1'b0;
    buf_wr  = 1'b0;
    prog_go = 1'b0;
    if (frame_end) begin
      // end of a program frame: every outcome drops the latch
      if (st_q == CS_ADDR || st_q == CS_DATA) begin
        wel_n = 1'b0;
        if (aligned && got_q && !tgt_locked) prog_go = 1'b1;
      end
      st_n = CS_OPC;
    end else if (!frame_act) begin
      st_n = CS_OPC;
    end else if (byte_vld) begin
      case (st_q)
        CS_OPC: begin
          if (rx_byte == OPC_RDST) begin
            st_n = CS_STAT;
          end else if (busy) begin
            st_n = CS_IGN;
          end else if (rx_byte == OPC_WREN) begin
            wel_n = 1'b1;
            st_n  = CS_IGN;
          end else if (rx_byte == OPC_PROG && wel_q) begin
            st_n    = CS_ADDR;
            acnt_n  = 2'd0;
            got_n   = 1'b0;
            buf_clr = 1'b1;
          end else begin
            st_n = CS_IGN;
          end
        end
        CS_ADDR: begin
          addr_n = MEM_AW'({addr_q, rx_byte});
          acnt_n = acnt_q + 2'd1;
          if (acnt_q == 2'd2) begin
            st_n  = CS_DATA;
            off_n = OFF_W'(rx_byte);
          end
        end
        CS_DATA: begin
          buf_wr = 1'b1;
          off_n  = off_q + OFF_W'(1);
          got_n  = 1'b1;
        end
        default: st_n = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_OPC;
      addr_q <= '0;
      acnt_q <= 2'd0;
      off_q  <= '0;
      got_q  <= 1'b0;
      wel_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      acnt_q <= acnt_n;
      off_q  <= off_n;
      got_q  <= got_n;
      wel_q  <= wel_n;
    end
  end
endmodule

// File: rtl/pp_flash_prog_chk.sv
module pp_flash_prog_chk
  import pp_pkg::*;
#(
  parameter int PROG_CYCLES = 1000
) (
  input logic    clk,
  input logic    rst_n,
  input logic    busy,
  input logic    wel,
  input logic    frame_end,
  input logic    aligned,
  input logic    got_data,
  input logic    locked,
  input logic    byte_vld,
  input cmd_st_e st
);
  int unsigned busy_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt_q <= 0;
    else if (busy) busy_cnt_q <= busy_cnt_q + 1;
    else           busy_cnt_q <= 0;
  end

  // R2
  prog_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // R5
  prog_whole_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_end && aligned && got_data));
  // R5
  abort_drops_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && (st == CS_ADDR || st == CS_DATA)) |=> !wel);
  // R6
  prog_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(locked));
  // R7
  wel_low_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wel);
  // R7
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt_q == PROG_CYCLES));
  // R9
  busy_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && st == CS_OPC && busy) |=> (st != CS_ADDR));
endmodule

bind pp_flash_prog pp_flash_prog_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel_q), .frame_end(frame_end),
  .aligned(aligned), .got_data(got_q), .locked(tgt_locked), .byte_vld(byte_vld), .st(st_q)
);

// File: tb/test_pp_flash_prog.sv
module test_pp_flash_prog;
  localparam int PC = 1000;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sck, mosi;
  logic       miso;
  logic [1:0] lock;
  logic [9:0] peek_a;
  logic [7:0] peek_d;

  int         n_chk = 0, n_fail = 0;
  logic [7:0] mem_m [1024];
  logic       wel_m, err_m;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic [7:0] pdata[$];
  logic [7:0] st;

  always #4 clk = ~clk;

  pp_flash_prog #(.PROG_CYCLES(PC)) i_pp_flash_prog (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .sect_lock(lock), .peek_addr(peek_a), .peek_data(peek_d)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic spi_frame(input int nbits);
    logic [7:0] r;
    r = 8'd0;
    rx_q.delete();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      int bi;
      bi = i / 8;
      mosi = (bi < tx_q.size()) ? tx_q[bi][7 - (i % 8)] : 1'b0;
      repeat (4) @(negedge clk);
      r = {r[6:0], miso};
      if (i % 8 == 7) rx_q.push_back(r);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_stat(input bit busy);
    return {2'b00, err_m, 3'b000, wel_m, busy};
  endfunction

  task automatic rd_status(output logic [7:0] s);
    tx_q = {8'h05};
    spi_frame(16);
    s = rx_q[1];
  endtask

  task automatic wren();
    tx_q = {8'h06};
    spi_frame(8);
    wel_m = 1'b1;
  endtask

  function automatic void model_apply(input logic [23:0] a);
    logic [7:0] b [256];
    bit         u [256];
    logic [7:0] off, v;
    int         base;
    for (int i = 0; i < 256; i++) begin b[i] = 8'h00; u[i] = 1'b0; end
    off = a[7:0];
    foreach (pdata[k]) begin
      b[off] = pdata[k];
      u[off] = 1'b1;
      off = off + 8'd1;
    end
    base  = int'(a[9:8]) * 256;
    err_m = 1'b0;
    for (int i = 0; i < 256; i++) begin
      if (u[i]) begin
        v = mem_m[base + i] & b[i];
        mem_m[base + i] = v;
        if (v != b[i]) err_m = 1'b1;
      end
    end
  endfunction

  task automatic prog(input logic [23:0] a);
    bit locked;
    tx_q = {8'h02, a[23:16], a[15:8], a[7:0]};
    foreach (pdata[k]) tx_q.push_back(pdata[k]);
    spi_frame(32 + 8 * pdata.size());
    locked = a[9] ? lock[1] : lock[0];
    if (wel_m && !locked) model_apply(a);
    wel_m = 1'b0;
  endtask

  task automatic wait_done();
    repeat (PC + 20) @(negedge clk);
  endtask

  task automatic chk_page(input int page, input string req);
    int bad;
    int first;
    bad = 0;
    first = -1;
    for (int i = 0; i < 256; i++) begin
      peek_a = 10'(page * 256 + i);
      #1;
      if (peek_d !== mem_m[page * 256 + i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    chk(bad == 0, req, bad, 0);
    if (bad != 0) $display("  first differing offset %0h", first);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; lock = 2'b10; peek_a = '0; rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem_m[i] = 8'hFF;
    wel_m = 1'b0;
    err_m = 1'b0;
    void'($urandom(32'd5150));
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    peek_a = 10'd0; #1;
    chk(peek_d == 8'hFF, "R11 array byte 0", peek_d, 8'hFF);
    peek_a = 10'h3FF; #1;
    chk(peek_d == 8'hFF, "R11 array last byte", peek_d, 8'hFF);
    rd_status(st);
    chk(st == 8'h00, "R11 status", st, 8'h00);

    // R2 program without write enable
    pdata = {8'hAA};
    prog(24'h000010);
    wait_done();
    chk_page(0, "R2 no latch, page 0 untouched");
    wren();
    rd_status(st);
    chk(st == exp_stat(1'b0), "R2 latch set by 06h", st, exp_stat(1'b0));

    // R1 wrap within page
    pdata = {8'h11, 8'h22, 8'h33};
    prog(24'h0000FE);
    tx_q = {8'h05};
    spi_frame(24);
    chk(rx_q[1] == exp_stat(1'b1), "R7 busy set, latch cleared", rx_q[1], exp_stat(1'b1));
    chk(rx_q[2] == rx_q[1], "R8 status byte repeats", rx_q[2], rx_q[1]);
    // R9 write enable ignored while busy
    tx_q = {8'h06};
    spi_frame(8);
    rd_status(st);
    chk(st == exp_stat(1'b1), "R9 06h ignored while busy", st, exp_stat(1'b1));
    wait_done();
    rd_status(st);
    chk(st == exp_stat(1'b0), "R7 busy released", st, exp_stat(1'b0));
    chk_page(0, "R1 wrap FE,FF,00");
    peek_a = 10'h001; #1;
    chk(peek_d == 8'hFF, "R4 offset 01 untouched", peek_d, 8'hFF);

    // R3 overlong data
    wren();
    pdata.delete();
    for (int i = 0; i < 300; i++) pdata.push_back(8'((i * 7 + 3) & 8'hFF));
    prog(24'h000110);
    wait_done();
    chk_page(1, "R3 last 256 bytes kept");

    // R10 bit clash sets error, next good program clears it
    wren(); pdata = {8'h0F}; prog(24'h000050); wait_done();
    wren(); pdata = {8'hF0}; prog(24'h000050); wait_done();
    rd_status(st);
    chk(st == exp_stat(1'b0) && st[5], "R10 error bit set", st, exp_stat(1'b0));
    peek_a = 10'h050; #1;
    chk(peek_d == 8'h00, "R10 AND merge", peek_d, 8'h00);
    wren(); pdata = {8'h00}; prog(24'h000060); wait_done();
    rd_status(st);
    chk(st == 8'h00, "R10 error cleared by next cycle", st, 8'h00);

    // R5 aborts
    wren();
    tx_q = {8'h02, 8'h00, 8'h00, 8'h70, 8'h55};
    spi_frame(37);
    wel_m = 1'b0;
    rd_status(st);
    chk(st == exp_stat(1'b0), "R5 partial byte abort", st, exp_stat(1'b0));
    wren();
    tx_q = {8'h02, 8'h00, 8'h00};
    spi_frame(24);
    wel_m = 1'b0;
    rd_status(st);
    chk(st == exp_stat(1'b0), "R5 short address abort", st, exp_stat(1'b0));
    wren();
    tx_q = {8'h02, 8'h00, 8'h00, 8'h70};
    spi_frame(32);
    wel_m = 1'b0;
    rd_status(st);
    chk(st == exp_stat(1'b0), "R5 no data abort", st, exp_stat(1'b0));
    chk_page(0, "R5 nothing programmed");

    // R6 locked sector
    wren();
    pdata = {8'h00, 8'h00};
    prog(24'h000210);
    rd_status(st);
    chk(st == exp_stat(1'b0), "R6 locked target ignored", st, exp_stat(1'b0));
    chk_page(2, "R6 locked page untouched");

    // random programs into sector 0, high address bits alias
    for (int k = 0; k < 10; k++) begin
      logic [23:0] a;
      int n;
      a = 24'($urandom);
      a[9] = 1'b0;
      n = 1 + int'($urandom % 40);
      pdata.delete();
      for (int j = 0; j < n; j++) pdata.push_back(8'($urandom));
      wren();
      prog(a);
      wait_done();
      chk_page(int'(a[9:8]), "R1 R4 random program");
      rd_status(st);
      chk(st == exp_stat(1'b0), "R10 random error flag", st, exp_stat(1'b0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule